// File: doc/BRIEF.md
# Piecewise Quadratic Sigmoid Approximator

This block computes an approximation of the logistic function 1/(1+e^-x) for a stream of signed fixed-point samples, one sample per clock. Every input carries eight fractional bits. The result is an unsigned fraction in the range 0 to 1 that keeps eight fractional bits. It is meant for hidden-layer neurons in a pipelined network evaluator, where the squashing step has to keep up with the multiply-accumulate rate and must not use a lookup memory.

The block folds the input to its magnitude. Any magnitude of 8.0 or more is treated as saturated. Below that limit, a bank of comparators places the magnitude in one of five intervals. Each interval holds three coefficients of a second-order expansion about its own centre point. The polynomial is evaluated in two registered multiplier stages with full-precision accumulation. The result is rounded once, to the nearest 1/256. Negative inputs are then mirrored as one minus the result. Interval bounds, centre points and coefficients are parameters, so a different fit can be loaded without touching the datapath. A valid flag travels alongside the data, and every result leaves exactly ten clocks after its input.

Top module: `sigmoid_pq`

## Requirements
- R1: `in_data` is two's complement with 8 fractional bits, so the code 256 stands for +1.0 and the code 0xFF00 for -1.0. `out_data` is unsigned with 8 fractional bits, so 256 stands for 1.0. For the input code 256 the output is 186 to 188, and for -256 it is 68 to 70.
- R2: For every input code in the range -2047 to 2047 and every saturated code, |out_data/256 - 1/(1+e^-(x/256))| is at most 0.005.
- R3: For any code x with 0 < |x| < 2048, the outputs for x and for -x add up to exactly 256.
- R4: Any input with a value of +8.0 or more (code 0x0800 to 0x7FFF) yields exactly 256.
- R5: Any input with a value of -8.0 or less (code 0x8000 to 0xF800) yields exactly 0.
- R6: `out_valid` equals `in_valid` delayed by exactly 10 clocks. A new sample is accepted on every clock, and a clock with `in_valid` low produces a clock with `out_valid` low.
- R7: A valid result never exceeds 256. A valid result for an in-range input of zero or more is at least 127, and a valid result for an in-range negative input is at most 129.
- R8: While `rst_n` is low, `out_valid` is low. After release, no result is flagged valid until an input accepted after the release has crossed the pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_data` as a sample to convert |
| in_data | input | 16 | Signed input, 7 integer and 8 fractional bits |
| out_valid | output | 1 | Marks `out_data` as a result |
| out_data | output | 9 | Approximated sigmoid, unsigned, 8 fractional bits |

## Verification
Within one clock, a new sample enters the first stage while an older sample leaves the last, and samples from different intervals, signs and saturation classes sit side by side in the pipeline. The bench provokes this by streaming every code back-to-back, each positive code followed directly by its mirror, so that the mirror sum and the interval edges are judged on adjacent outputs. A reset is also asserted while the pipeline is full of valid samples. The bench then checks that nothing accepted before or during that reset emerges as valid, and that the samples fed after release come out on schedule.

// File: rtl/sigmoid_pq.sv
module sigmoid_pq #(
  parameter int DW      = 16,
  parameter int FRAC    = 8,
  parameter int SAT_INT = 8,
  parameter int NSEG    = 5,
  parameter int CF      = 16,
  parameter int CW      = 18,
  parameter logic [NSEG*DW-1:0] SEG_LO = {16'd1280, 16'd832, 16'd512, 16'd256, 16'd0},
  parameter logic [NSEG*DW-1:0] SEG_X0 = {16'd1664, 16'd1056, 16'd672, 16'd384, 16'd128},
  parameter logic [NSEG*CW-1:0] COEF_A = {18'sd65438, 18'sd64494, 18'sd61109, 18'sd53581, 18'sd40793},
  parameter logic [NSEG*CW-1:0] COEF_B = {18'sd98, 18'sd1026, 18'sd4128, 18'sd9774, 18'sd15401},
  parameter logic [NSEG*CW-1:0] COEF_C = {-18'sd49, -18'sd497, -18'sd1785, -18'sd3104, -18'sd1886}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_data,
  output logic              out_valid,
  output logic [FRAC:0]     out_data
);
  localparam int OW  = FRAC + 1;
  localparam int LAT = 10;
  localparam int LIM = SAT_INT << FRAC;
  localparam int SW  = (NSEG > 1) ? $clog2(NSEG) : 1;
  localparam int DDW = DW + 1;
  localparam int SQW = 2 * DDW;
  localparam int BDW = CW + DDW;
  localparam int ACC = CW + SQW + 2;
  localparam int RS  = CF + FRAC;
  localparam int AGW = $clog2(LAT + 1);
  localparam logic [OW-1:0] ONE_V = OW'(1) << FRAC;

  logic [LAT-1:0] vld_sr, neg_sr, sat_sr;
  logic [DW-1:0]  mag_in, mag1;
  logic           sat_in;
  logic [NSEG-1:0] ge;
  logic [SW-1:0]  sel;

  logic signed [DDW-1:0] d2;
  logic signed [CW-1:0]  a2, b2, c2, a3, c3, a4, c4, c5;
  logic signed [SQW-1:0] sq3, sq4, sq5;
  logic signed [BDW-1:0] bd3, bd4;
  logic signed [ACC-1:0] lin5, lin6, lin7, cq6, cq7, acc8, rnd;
  logic [OW-1:0]         f9, y10;

  assign mag_in = in_data[DW-1] ? (~in_data + 1'b1) : in_data;
  assign sat_in = mag_in >= DW'(LIM);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vld_sr <= '0;
    else        vld_sr <= {vld_sr[LAT-2:0], in_valid};

  always_ff @(posedge clk) begin
    neg_sr <= {neg_sr[LAT-2:0], in_data[DW-1]};
    sat_sr <= {sat_sr[LAT-2:0], sat_in};
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_cmp
    assign ge[i] = mag1 >= SEG_LO[i*DW +: DW];
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NSEG; i++)
      if (ge[i]) sel = SW'(i);
  end

  assign rnd = (acc8 + (ACC'(1) <<< (RS - 1))) >>> RS;

  always_ff @(posedge clk) begin
    mag1 <= mag_in;

    d2 <= $signed({1'b0, mag1}) - $signed({1'b0, SEG_X0[sel*DW +: DW]});
    a2 <= COEF_A[sel*CW +: CW];
    b2 <= COEF_B[sel*CW +: CW];
    c2 <= COEF_C[sel*CW +: CW];

    sq3 <= SQW'(d2) * SQW'(d2);
    bd3 <= BDW'(b2) * BDW'(d2);
    a3  <= a2;
    c3  <= c2;

    sq4 <= sq3;
    bd4 <= bd3;
    a4  <= a3;
    c4  <= c3;

    lin5 <= (ACC'(a4) <<< (2 * FRAC)) + (ACC'(bd4) <<< FRAC);
    sq5  <= sq4;
    c5   <= c4;

    cq6  <= ACC'(c5) * ACC'(sq5);
    lin6 <= lin5;

    cq7  <= cq6;
    lin7 <= lin6;

    acc8 <= lin7 + cq7;

    if (rnd < 0)                 f9 <= '0;
    else if (rnd > ACC'(ONE_V))  f9 <= ONE_V;
    else                         f9 <= rnd[OW-1:0];

    if (sat_sr[LAT-2])      y10 <= neg_sr[LAT-2] ? '0 : ONE_V;
    else if (neg_sr[LAT-2]) y10 <= ONE_V - f9;
    else                    y10 <= f9;
  end

  assign out_valid = vld_sr[LAT-1];
  assign out_data  = y10;

  logic [AGW-1:0] age_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   age_q <= '0;
    else if (age_q != AGW'(LAT))  age_q <= age_q + 1'b1;

  a_r6_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    age_q == AGW'(LAT) |-> out_valid == $past(in_valid, LAT));

  a_r7_not_above_one: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data <= ONE_V);

  a_r4_pos_saturation: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == AGW'(LAT)) && $past(in_valid && !in_data[DW-1] && sat_in, LAT) |-> out_data == ONE_V);

  a_r5_neg_saturation: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == AGW'(LAT)) && $past(in_valid && in_data[DW-1] && sat_in, LAT) |-> out_data == '0);

  a_r7_upper_half: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == AGW'(LAT)) && $past(in_valid && !in_data[DW-1] && !sat_in, LAT)
      |-> out_data >= OW'((1 << (FRAC - 1)) - 1));

  a_r8_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    age_q < AGW'(LAT) |-> !out_valid || age_q != '0);
endmodule

// File: tb/sigmoid_pq_test.sv
`timescale 1ns/1ps
module sigmoid_pq_test;
  localparam int LAT = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [8:0]  out_data;

  always #2 clk = ~clk;

  sigmoid_pq uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic        hv [16];
  logic [15:0] hx [16];
  int k = 0;
  logic        p_v = 0;
  logic [15:0] p_x = '0;
  int          p_y = 0;

  function automatic real sig(input logic [15:0] x);
    real r;
    r = $itor($signed(x)) / 256.0;
    return 1.0 / (1.0 + $exp(-r));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic observe();
    int slot, sx, y, ei;
    logic ev;
    logic [15:0] x;
    real e, diff;
    slot = (k - LAT) & 15;
    ev = hv[slot];
    chk(out_valid == ev, "R6 valid delayed by 10", int'(out_valid), int'(ev));
    if (ev && out_valid) begin
      x  = hx[slot];
      sx = $signed(x);
      y  = int'(out_data);
      e  = sig(x);
      ei = $rtoi(e * 256.0 + 0.5);
      diff = y / 256.0 - e;
      if (diff < 0.0) diff = -diff;
      chk(diff <= 0.005, "R2 error bound", y, ei);
      chk(y <= 256, "R7 at most one", y, 256);
      if (sx >= 2048)       chk(y == 256, "R4 positive saturation", y, 256);
      else if (sx <= -2048) chk(y == 0, "R5 negative saturation", y, 0);
      else if (sx >= 0)     chk(y >= 127, "R7 upper half", y, 127);
      else                  chk(y <= 129, "R7 lower half", y, 129);
      if (sx == 256)  chk(y >= 186 && y <= 188, "R1 code +1.0", y, 187);
      if (sx == -256) chk(y >= 68 && y <= 70, "R1 code -1.0", y, 69);
      if (p_v && sx != 0 && sx > -2048 && sx < 2048 && $signed(p_x) == -sx)
        chk(p_y + y == 256, "R3 mirror sum", p_y + y, 256);
      p_v = 1; p_x = x; p_y = y;
    end else p_v = 0;
  endtask

  task automatic step(input bit v, input logic [15:0] x);
    observe();
    in_valid = v;
    in_data  = x;
    hv[k & 15] = v;
    hx[k & 15] = x;
    k++;
    @(negedge clk);
  endtask

  task automatic pair(input logic [15:0] x);
    step(1'b1, x);
    step(1'b1, -x);
  endtask

  task automatic do_reset(input int cycles);
    rst_n = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      in_valid = 1'b1;
      in_data  = 16'($urandom);
      @(negedge clk);
      chk(out_valid == 1'b0, "R8 held in reset", int'(out_valid), 0);
    end
    for (int i = 0; i < 16; i++) hv[i] = 1'b0;
    p_v = 0;
    rst_n = 1'b1;
  endtask

  initial begin
    logic [31:0] r;
    logic [11:0] s12;
    logic [15:0] x;
    void'($urandom(32'd7919));
    @(negedge clk);
    do_reset(4);

    step(1'b1, 16'd0);
    pair(16'd1);   pair(16'd256); pair(16'd255); pair(16'd511); pair(16'd512);
    pair(16'd831); pair(16'd832); pair(16'd1279); pair(16'd1280); pair(16'd2047);
    step(1'b1, 16'h0800); step(1'b1, 16'hF800);
    step(1'b1, 16'h7FFF); step(1'b1, 16'h8000);
    step(1'b0, 16'd100);  step(1'b1, 16'h0180); step(1'b0, 16'd5);

    for (int i = 1; i < 32768; i++) pair(16'(i));

    for (int i = 0; i < 4000; i++) begin
      r   = $urandom;
      s12 = r[15:4];
      x   = r[0] ? {{4{s12[11]}}, s12} : r[31:16];
      step((r[3:2] != 2'b00), x);
    end

    for (int i = 0; i < 8; i++) step(1'b1, 16'(i * 97));
    do_reset(3);
    for (int i = 0; i < 6; i++) step(1'b0, 16'd0);
    for (int i = 0; i < 4; i++) pair(16'(300 + i));
    for (int i = 0; i < 14; i++) step(1'b0, 16'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #700000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d, expected completion", k);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule